// File: doc/BRIEF.md
# Fully Associative Translation Buffer with Scoped Invalidation

This block caches virtual-to-physical page translations in a small, fully associative array. Every entry is keyed by a virtual page tag, a partition number, a context number and a flag that marks the entry as a real (not virtual) mapping. Each entry also carries a physical page number and four page attributes: privileged, writable, side-effect and no-fault. A lookup presents a full virtual address together with its context, partition and real flag. One cycle later the block returns a hit flag, the physical address and the attributes. It also returns an uncacheable indication that the memory pipeline uses to bypass caches and to keep accesses in strict order.

A single write port carries three kinds of command. An insert either names its target slot directly or lets a rotating replacement pointer choose one. A demap removes entries at one of three scopes: one page, one context, or every entry of a partition. A flush empties the whole array. Before an insert lands, any older copy of the same mapping is removed, so a lookup never matches more than one entry. The page size is fixed at 8 KiB, which leaves 13 untranslated offset bits.

Top module: `tlb_fa`

## Requirements
- R1: After reset, every entry is invalid, the replacement pointer is 0, and `lk_hit`, `lk_pa`, the attribute outputs, `lk_unc` and `dm_err` are all 0.
- R2: A lookup with `lk_req` high is answered in the next cycle. It hits only if a valid entry matches all four of these: tag (`lk_va[63:13]`), partition, context and real flag. On a hit, `lk_pa` is the entry's physical page followed by `lk_va[12:0]`, and the attributes are the entry's own. On a miss, or when no lookup was made, all of these outputs are 0.
- R3: `lk_unc` is 1 exactly when the lookup hits and either the entry's side-effect attribute is set or bit 39 of `lk_pa` is 1.
- R4: A write with `wr_op`=0 is an insert. When `wr_direct` is 1, the insert writes slot `wr_idx`. If `wr_idx` is not below ENTRIES, the insert writes no slot and leaves the pointer alone.
- R5: An insert with `wr_direct`=0 writes the slot named by the replacement pointer. The pointer then advances by one, and wraps from ENTRIES-1 to 0. Direct inserts never move the pointer.
- R6: Before an insert is written, every valid entry with the same tag, partition, context and real flag is invalidated. At most one entry can therefore match any lookup.
- R7: A write with `wr_op`=1 is a demap, and its scope is taken from `wr_kind`. With `wr_kind`=0 (page demap), it invalidates the entries whose tag, partition, context and real flag all equal `wr_tag`, `wr_part`, `wr_ctx` and `wr_real`.
- R8: A demap with `wr_kind`=1 (context demap) invalidates every entry whose context and partition both match, whatever its tag and real flag.
- R9: A demap with `wr_kind`=2 (partition demap) invalidates every entry of partition `wr_part`.
- R10: A demap with `wr_kind`=3 is illegal. It raises `dm_err` for exactly one cycle, in the cycle after the command, and changes no entry.
- R11: A write with `wr_op`=2 invalidates every entry. A write with `wr_op`=3 does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_req | input | 1 | Lookup request |
| lk_va | input | 64 | Lookup virtual address |
| lk_ctx | input | 13 | Lookup context |
| lk_part | input | 8 | Lookup partition |
| lk_real | input | 1 | Lookup is a real-address translation |
| lk_hit | output | 1 | Registered hit |
| lk_pa | output | 40 | Registered physical address |
| lk_priv | output | 1 | Page is privileged |
| lk_wrt | output | 1 | Page is writable |
| lk_side | output | 1 | Page has side effects |
| lk_nf | output | 1 | Page is no-fault |
| lk_unc | output | 1 | Access is uncacheable and strictly ordered |
| wr_en | input | 1 | Write-port command valid |
| wr_op | input | 2 | 0 insert, 1 demap, 2 flush, 3 none |
| wr_tag | input | 51 | Virtual page tag (address bits 63:13) |
| wr_ctx | input | 13 | Context for insert or demap |
| wr_part | input | 8 | Partition for insert or demap |
| wr_real | input | 1 | Real flag for insert or page demap |
| wr_direct | input | 1 | Insert targets `wr_idx` instead of the pointer |
| wr_idx | input | 6 | Direct insert slot number |
| wr_kind | input | 2 | Demap scope: 0 page, 1 context, 2 partition, 3 illegal |
| wr_ppn | input | 27 | Physical page number for insert |
| wr_priv | input | 1 | Insert attribute: privileged |
| wr_wrt | input | 1 | Insert attribute: writable |
| wr_side | input | 1 | Insert attribute: side effect |
| wr_nf | input | 1 | Insert attribute: no-fault |
| dm_err | output | 1 | Illegal demap scope seen |

## Verification
The assertions check the following on every cycle:
- no more than one entry ever matches a lookup;
- a hit only ever follows a request, and a miss leaves the address and attribute outputs quiet;
- the uncacheable flag follows the side-effect attribute and physical bit 39;
- a flush leaves the array empty;
- an illegal demap scope raises the error flag and leaves the valid bits untouched.

Other behaviours can only be shown by the bench's scenarios, because they depend on command history:
- the pointer's visiting order and its wrap;
- a direct index overriding the pointer;
- the exact set of entries each demap scope keeps or removes;
- the replacement of a duplicate by a later insert.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  parameter int VA_W   = 64;
  parameter int PG_OFF = 13;
  parameter int PA_W   = 40;
  parameter int CTX_W  = 13;
  parameter int PART_W = 8;
  parameter int IDX_IN = 6;
  parameter int UNC_BIT = 39;
  localparam int TAG_W = VA_W - PG_OFF;
  localparam int PPN_W = PA_W - PG_OFF;

  typedef struct packed {
    logic [TAG_W-1:0]  tag;
    logic [PART_W-1:0] part;
    logic [CTX_W-1:0]  ctx;
    logic              rl;
  } tlb_key_t;

  typedef struct packed {
    logic [PPN_W-1:0] ppn;
    logic             priv;
    logic             wrt;
    logic             side;
    logic             nf;
  } tlb_data_t;

  typedef enum logic [1:0] {
    OP_INS   = 2'd0,
    OP_DEMAP = 2'd1,
    OP_FLUSH = 2'd2,
    OP_NOP   = 2'd3
  } wr_op_e;

  typedef enum logic [1:0] {
    DM_PAGE = 2'd0,
    DM_CTX  = 2'd1,
    DM_PART = 2'd2,
    DM_BAD  = 2'd3
  } dm_kind_e;
endpackage

// File: rtl/tlb_cam.sv
module tlb_cam import tlb_pkg::*; #(
  parameter int ENTRIES = 16
) (
  input  logic [ENTRIES-1:0] valid,
  input  tlb_key_t           keys [ENTRIES],
  input  tlb_key_t           key,
  input  logic               use_tag,
  input  logic               use_ctx,
  input  logic               use_real,
  output logic [ENTRIES-1:0] match
);
  // Per-entry comparator; masked fields always compare equal.
  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    logic tag_ok, ctx_ok, rl_ok, part_ok;
    assign tag_ok  = !use_tag  || (keys[i].tag == key.tag);
    assign ctx_ok  = !use_ctx  || (keys[i].ctx == key.ctx);
    assign rl_ok   = !use_real || (keys[i].rl  == key.rl);
    assign part_ok = (keys[i].part == key.part);
    assign match[i] = valid[i] && tag_ok && ctx_ok && rl_ok && part_ok;
  end
endmodule

// File: rtl/tlb_sel.sv
module tlb_sel import tlb_pkg::*; #(
  parameter int ENTRIES = 16
) (
  input  logic [ENTRIES-1:0] hit,
  input  tlb_data_t          data [ENTRIES],
  output tlb_data_t          sel
);
  // AND-OR mux; relies on the one-hot hit vector kept by insert dedup.
  always_comb begin
    sel = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      sel = sel | (data[i] & {$bits(tlb_data_t){hit[i]}});
    end
  end
endmodule

// File: rtl/tlb_repl.sv
module tlb_repl #(
  parameter int ENTRIES = 16,
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  output logic [IDX_W-1:0] ptr
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);
  logic [IDX_W-1:0] ptr_d;

  always_comb begin
    ptr_d = ptr;
    if (adv) begin
      ptr_d = (ptr == LAST) ? '0 : ptr + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr <= '0;
    else if (adv) ptr <= ptr_d;
  end
endmodule

// File: rtl/tlb_fa.sv
module tlb_fa import tlb_pkg::*; #(
  parameter int ENTRIES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_req,
  input  logic [VA_W-1:0]   lk_va,
  input  logic [CTX_W-1:0]  lk_ctx,
  input  logic [PART_W-1:0] lk_part,
  input  logic              lk_real,
  output logic              lk_hit,
  output logic [PA_W-1:0]   lk_pa,
  output logic              lk_priv,
  output logic              lk_wrt,
  output logic              lk_side,
  output logic              lk_nf,
  output logic              lk_unc,
  input  logic              wr_en,
  input  logic [1:0]        wr_op,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [CTX_W-1:0]  wr_ctx,
  input  logic [PART_W-1:0] wr_part,
  input  logic              wr_real,
  input  logic              wr_direct,
  input  logic [IDX_IN-1:0] wr_idx,
  input  logic [1:0]        wr_kind,
  input  logic [PPN_W-1:0]  wr_ppn,
  input  logic              wr_priv,
  input  logic              wr_wrt,
  input  logic              wr_side,
  input  logic              wr_nf,
  output logic              dm_err
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  if (ENTRIES > 64 || ENTRIES < 2) begin : g_size_chk
    $error("tlb_fa: ENTRIES must lie in 2..64");
  end

  tlb_key_t           keys_q [ENTRIES];
  tlb_data_t          data_q [ENTRIES];
  logic [ENTRIES-1:0] valid_q, valid_d;
  logic [ENTRIES-1:0] ent_we, wmatch, hit_vec;
  logic [IDX_W-1:0]   ptr;

  wr_op_e   op;
  dm_kind_e kind;
  logic     do_ins, do_dmp, do_fl, use_tag, use_ctx, rot_adv;
  tlb_key_t  wkey, lkey;
  tlb_data_t wdata, hdata;

  // Command decode
  always_comb begin
    op      = wr_op_e'(wr_op);
    kind    = dm_kind_e'(wr_kind);
    do_ins  = wr_en && (op == OP_INS);
    do_dmp  = wr_en && (op == OP_DEMAP);
    do_fl   = wr_en && (op == OP_FLUSH);
    use_tag = !(do_dmp && (kind != DM_PAGE));
    use_ctx = !(do_dmp && (kind == DM_PART));
    rot_adv = do_ins && !wr_direct;
    wkey    = '{tag: wr_tag, part: wr_part, ctx: wr_ctx, rl: wr_real};
    wdata   = '{ppn: wr_ppn, priv: wr_priv, wrt: wr_wrt, side: wr_side, nf: wr_nf};
    lkey    = '{tag: lk_va[VA_W-1:PG_OFF], part: lk_part, ctx: lk_ctx, rl: lk_real};
  end

  tlb_cam #(.ENTRIES(ENTRIES)) u_wcam (
    .valid(valid_q), .keys(keys_q), .key(wkey),
    .use_tag(use_tag), .use_ctx(use_ctx), .use_real(use_tag),
    .match(wmatch)
  );

  tlb_cam #(.ENTRIES(ENTRIES)) u_lcam (
    .valid(valid_q), .keys(keys_q), .key(lkey),
    .use_tag(1'b1), .use_ctx(1'b1), .use_real(1'b1),
    .match(hit_vec)
  );

  tlb_sel #(.ENTRIES(ENTRIES)) u_sel (
    .hit(hit_vec), .data(data_q), .sel(hdata)
  );

  tlb_repl #(.ENTRIES(ENTRIES)) u_repl (
    .clk(clk), .rst_n(rst_n), .adv(rot_adv), .ptr(ptr)
  );

  // Target slot decode: direct index or rotating pointer
  for (genvar i = 0; i < ENTRIES; i++) begin : g_tgt
    localparam logic [IDX_IN-1:0] SLOT_D = IDX_IN'(i);
    localparam logic [IDX_W-1:0]  SLOT_P = IDX_W'(i);
    assign ent_we[i] = do_ins && (wr_direct ? (wr_idx == SLOT_D) : (ptr == SLOT_P));
  end

  // Valid next state
  always_comb begin
    valid_d = valid_q;
    if (do_fl) begin
      valid_d = '0;
    end else if (do_dmp) begin
      if (kind != DM_BAD) valid_d = valid_q & ~wmatch;
    end else if (do_ins) begin
      valid_d = (valid_q & ~wmatch) | ent_we;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else        valid_q <= valid_d;
  end

  // Entry payload storage, no reset, per-slot enable
  always_ff @(posedge clk) begin
    for (int i = 0; i < ENTRIES; i++) begin
      if (ent_we[i]) begin
        keys_q[i] <= wkey;
        data_q[i] <= wdata;
      end
    end
  end

  // Lookup response next state
  logic            hit_d, unc_d, err_d;
  logic [PA_W-1:0] pa_d;
  tlb_data_t       attr_d;

  always_comb begin
    hit_d  = lk_req && (|hit_vec);
    pa_d   = hit_d ? {hdata.ppn, lk_va[PG_OFF-1:0]} : '0;
    attr_d = hit_d ? hdata : '0;
    unc_d  = hit_d && (hdata.side || pa_d[UNC_BIT]);
    err_d  = do_dmp && (kind == DM_BAD);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lk_hit  <= 1'b0;
      lk_pa   <= '0;
      lk_priv <= 1'b0;
      lk_wrt  <= 1'b0;
      lk_side <= 1'b0;
      lk_nf   <= 1'b0;
      lk_unc  <= 1'b0;
      dm_err  <= 1'b0;
    end else begin
      lk_hit  <= hit_d;
      lk_pa   <= pa_d;
      lk_priv <= attr_d.priv;
      lk_wrt  <= attr_d.wrt;
      lk_side <= attr_d.side;
      lk_nf   <= attr_d.nf;
      lk_unc  <= unc_d;
      dm_err  <= err_d;
    end
  end
endmodule

// File: rtl/tlb_fa_chk.sv
module tlb_fa_chk #(
  parameter int ENTRIES = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr_en,
  input logic [1:0]         wr_op,
  input logic [1:0]         wr_kind,
  input logic               lk_req,
  input logic               lk_hit,
  input logic [39:0]        lk_pa,
  input logic               lk_priv,
  input logic               lk_wrt,
  input logic               lk_side,
  input logic               lk_nf,
  input logic               lk_unc,
  input logic               dm_err,
  input logic [ENTRIES-1:0] valid_q,
  input logic [ENTRIES-1:0] hit_vec
);
  logic bad_dm, flush_cmd;
  assign bad_dm    = wr_en && (wr_op == 2'd1) && (wr_kind == 2'd3);
  assign flush_cmd = wr_en && (wr_op == 2'd2);

  AST_HIT_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> $past(lk_req)); // R2
  AST_MISS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> (lk_pa == '0 && !lk_priv && !lk_wrt && !lk_side && !lk_nf)); // R2
  AST_UNC_RULE: assert property (@(posedge clk) disable iff (!rst_n)
    lk_unc == (lk_hit && (lk_side || lk_pa[39]))); // R3
  AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec)); // R6
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    flush_cmd |=> (valid_q == '0)); // R11
  AST_ERR_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    dm_err |-> $past(bad_dm)); // R10
  AST_ERR_RAISED: assert property (@(posedge clk) disable iff (!rst_n)
    bad_dm |=> dm_err); // R10
  AST_ERR_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    bad_dm |=> $stable(valid_q)); // R10
endmodule

bind tlb_fa tlb_fa_chk #(.ENTRIES(ENTRIES)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_op(wr_op), .wr_kind(wr_kind),
  .lk_req(lk_req), .lk_hit(lk_hit), .lk_pa(lk_pa), .lk_priv(lk_priv),
  .lk_wrt(lk_wrt), .lk_side(lk_side), .lk_nf(lk_nf), .lk_unc(lk_unc),
  .dm_err(dm_err), .valid_q(valid_q), .hit_vec(hit_vec)
);

// File: tb/sim_tlb_fa.sv
`timescale 1ns/1ps
module sim_tlb_fa;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n;
  logic        lk_req, lk_real;
  logic [63:0] lk_va;
  logic [12:0] lk_ctx;
  logic [7:0]  lk_part;
  logic        lk_hit, lk_priv, lk_wrt, lk_side, lk_nf, lk_unc;
  logic [39:0] lk_pa;
  logic        wr_en, wr_real, wr_direct, wr_priv, wr_wrt, wr_side, wr_nf;
  logic [1:0]  wr_op, wr_kind;
  logic [50:0] wr_tag;
  logic [12:0] wr_ctx;
  logic [7:0]  wr_part;
  logic [5:0]  wr_idx;
  logic [26:0] wr_ppn;
  logic        dm_err;

  tlb_fa u0 (.*);

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp, string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wr_cmd(logic [1:0] op, logic [1:0] kind, logic dir, logic [5:0] idx,
                        logic [50:0] tag, logic rl, logic [12:0] ctx, logic [7:0] part,
                        logic [26:0] ppn, logic [3:0] attr, output logic err);
    @(negedge clk);
    wr_en = 1'b1; wr_op = op; wr_kind = kind; wr_direct = dir; wr_idx = idx;
    wr_tag = tag; wr_real = rl; wr_ctx = ctx; wr_part = part; wr_ppn = ppn;
    {wr_priv, wr_wrt, wr_side, wr_nf} = attr;
    @(negedge clk);
    err = dm_err;
    wr_en = 1'b0;
  endtask

  task automatic ins(logic dir, logic [5:0] idx, logic [50:0] tag, logic [12:0] ctx,
                     logic [7:0] part, logic [26:0] ppn);
    logic e;
    wr_cmd(2'd0, 2'd0, dir, idx, tag, 1'b0, ctx, part, ppn, 4'b0000, e);
  endtask

  task automatic look(logic [63:0] va, logic [12:0] ctx, logic [7:0] part, logic rl);
    @(negedge clk);
    lk_req = 1'b1; lk_va = va; lk_ctx = ctx; lk_part = part; lk_real = rl;
    @(negedge clk);
    lk_req = 1'b0;
  endtask

  // Attribute order in vectors: {priv, wrt, side, nf}
  typedef struct packed {
    logic [1:0]  op;
    logic [1:0]  kind;
    logic        dir;
    logic [5:0]  idx;
    logic [50:0] tag;
    logic        rl;
    logic [12:0] ctx;
    logic [7:0]  part;
    logic [26:0] ppn;
    logic [3:0]  attr;
    logic [63:0] lva;
    logic [12:0] lctx;
    logic [7:0]  lpart;
    logic        lrl;
    logic        ehit;
    logic [39:0] epa;
    logic [3:0]  eattr;
    logic        eunc;
  } vec_t;

  localparam logic [50:0] TA = 51'h1234_5678;
  localparam logic [50:0] TB = 51'h20;
  localparam logic [50:0] TC = 51'h4_0000_0000_0001;
  localparam int NV = 11;
  localparam vec_t VT [NV] = '{
    '{2'd0,2'd0,1'b1,6'd3,TA,1'b0,13'd5,8'd1,27'h0ABCD,4'b0100,
      {TA,13'h0123},13'd5,8'd1,1'b0, 1'b1,{27'h0ABCD,13'h0123},4'b0100,1'b0},
    '{2'd3,2'd0,1'b0,6'd0,51'd0,1'b0,13'd0,8'd0,27'd0,4'b0000,
      {TA,13'h0123},13'd6,8'd1,1'b0, 1'b0,40'd0,4'b0000,1'b0},
    '{2'd3,2'd0,1'b0,6'd0,51'd0,1'b0,13'd0,8'd0,27'd0,4'b0000,
      {TA,13'h0123},13'd5,8'd2,1'b0, 1'b0,40'd0,4'b0000,1'b0},
    '{2'd3,2'd0,1'b0,6'd0,51'd0,1'b0,13'd0,8'd0,27'd0,4'b0000,
      {TA,13'h0123},13'd5,8'd1,1'b1, 1'b0,40'd0,4'b0000,1'b0},
    '{2'd0,2'd0,1'b0,6'd0,TB,1'b0,13'd5,8'd1,27'h4000000,4'b0000,
      {TB,13'h1FFF},13'd5,8'd1,1'b0, 1'b1,{27'h4000000,13'h1FFF},4'b0000,1'b1},
    '{2'd0,2'd0,1'b0,6'd0,TC,1'b1,13'd7,8'd1,27'h1,4'b0010,
      {TC,13'h0},13'd7,8'd1,1'b1, 1'b1,{27'h1,13'h0},4'b0010,1'b1},
    '{2'd1,2'd0,1'b0,6'd0,TA,1'b0,13'd5,8'd1,27'd0,4'b0000,
      {TA,13'h0123},13'd5,8'd1,1'b0, 1'b0,40'd0,4'b0000,1'b0},
    '{2'd3,2'd0,1'b0,6'd0,51'd0,1'b0,13'd0,8'd0,27'd0,4'b0000,
      {TB,13'h1FFF},13'd5,8'd1,1'b0, 1'b1,{27'h4000000,13'h1FFF},4'b0000,1'b1},
    '{2'd1,2'd1,1'b0,6'd0,51'd0,1'b0,13'd5,8'd1,27'd0,4'b0000,
      {TB,13'h1FFF},13'd5,8'd1,1'b0, 1'b0,40'd0,4'b0000,1'b0},
    '{2'd3,2'd0,1'b0,6'd0,51'd0,1'b0,13'd0,8'd0,27'd0,4'b0000,
      {TC,13'h0},13'd7,8'd1,1'b1, 1'b1,{27'h1,13'h0},4'b0010,1'b1},
    '{2'd1,2'd2,1'b0,6'd0,51'd0,1'b0,13'd0,8'd1,27'd0,4'b0000,
      {TC,13'h0},13'd7,8'd1,1'b1, 1'b0,40'd0,4'b0000,1'b0}
  };

  function automatic string row_req(int r);
    case (r)
      0: return "R4";
      1, 2, 3: return "R2";
      4: return "R3";
      5: return "R5";
      6, 7: return "R7";
      8, 9: return "R8";
      default: return "R9";
    endcase
  endfunction

  initial begin
    #(4 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic e;
    rst_n = 1'b0; lk_req = 1'b0; lk_va = '0; lk_ctx = '0; lk_part = '0; lk_real = 1'b0;
    wr_en = 1'b0; wr_op = 2'd3; wr_kind = '0; wr_direct = 1'b0; wr_idx = '0;
    wr_tag = '0; wr_real = 1'b0; wr_ctx = '0; wr_part = '0; wr_ppn = '0;
    wr_priv = 1'b0; wr_wrt = 1'b0; wr_side = 1'b0; wr_nf = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    chk("R1", 64'(lk_hit), 64'd0, "hit after reset");
    chk("R1", 64'(dm_err), 64'd0, "dm_err after reset");
    look({TA, 13'h0123}, 13'd5, 8'd1, 1'b0);
    chk("R1", 64'(lk_hit), 64'd0, "lookup into empty array");
    chk("R1", 64'(lk_pa), 64'd0, "pa from empty array");

    // Vector table
    for (int r = 0; r < NV; r++) begin
      vec_t v;
      v = VT[r];
      if (v.op != 2'd3)
        wr_cmd(v.op, v.kind, v.dir, v.idx, v.tag, v.rl, v.ctx, v.part, v.ppn, v.attr, e);
      look(v.lva, v.lctx, v.lpart, v.lrl);
      chk(row_req(r), 64'(lk_hit), 64'(v.ehit), $sformatf("row %0d hit", r));
      chk(row_req(r), 64'(lk_pa), 64'(v.epa), $sformatf("row %0d pa", r));
      chk(row_req(r), 64'({lk_priv, lk_wrt, lk_side, lk_nf}), 64'(v.eattr),
          $sformatf("row %0d attrs", r));
      chk(row_req(r), 64'(lk_unc), 64'(v.eunc), $sformatf("row %0d unc", r));
    end

    // R5: the pointer stands at 2 after two rotating inserts; direct inserts leave it
    wr_cmd(2'd2, 2'd0, 1'b0, 6'd0, 51'd0, 1'b0, 13'd0, 8'd0, 27'd0, 4'b0, e);
    ins(1'b1, 6'd2, 51'h100, 13'd1, 8'd3, 27'h11);
    ins(1'b0, 6'd0, 51'h101, 13'd1, 8'd3, 27'h12);
    look({51'h100, 13'h0}, 13'd1, 8'd3, 1'b0);
    chk("R5", 64'(lk_hit), 64'd0, "direct entry replaced by rotating insert at slot 2");
    look({51'h101, 13'h0}, 13'd1, 8'd3, 1'b0);
    chk("R5", 64'(lk_pa), {24'd0, 27'h12, 13'h0}, "rotating entry pa");
    for (int k = 0; k < 14; k++) ins(1'b0, 6'd0, 51'h200 + 51'(k), 13'd1, 8'd3, 27'h20 + 27'(k));
    ins(1'b0, 6'd0, 51'h300, 13'd1, 8'd3, 27'h30);
    ins(1'b0, 6'd0, 51'h301, 13'd1, 8'd3, 27'h31);
    look({51'h101, 13'h0}, 13'd1, 8'd3, 1'b0);
    chk("R5", 64'(lk_hit), 64'd0, "pointer wrapped and reused slot 2");
    look({51'h301, 13'h0}, 13'd1, 8'd3, 1'b0);
    chk("R5", 64'(lk_hit), 64'd1, "newest rotating entry");
    look({51'h200, 13'h0}, 13'd1, 8'd3, 1'b0);
    chk("R5", 64'(lk_pa), {24'd0, 27'h20, 13'h0}, "slot 3 kept");
    look({51'h20D, 13'h0}, 13'd1, 8'd3, 1'b0);
    chk("R5", 64'(lk_hit), 64'd1, "slot 0 reached at wrap");

    // R4: out-of-range direct index writes nothing
    ins(1'b1, 6'd20, 51'h400, 13'd2, 8'd4, 27'h40);
    look({51'h400, 13'h0}, 13'd2, 8'd4, 1'b0);
    chk("R4", 64'(lk_hit), 64'd0, "index 20 ignored");

    // R6: duplicate removal
    ins(1'b1, 6'd5, 51'h500, 13'd9, 8'd6, 27'h1);
    ins(1'b1, 6'd9, 51'h500, 13'd9, 8'd6, 27'h2);
    look({51'h500, 13'h0AA}, 13'd9, 8'd6, 1'b0);
    chk("R6", 64'(lk_pa), {24'd0, 27'h2, 13'h0AA}, "second direct insert wins");
    ins(1'b0, 6'd0, 51'h500, 13'd9, 8'd6, 27'h3);
    look({51'h500, 13'h0AA}, 13'd9, 8'd6, 1'b0);
    chk("R6", 64'(lk_pa), {24'd0, 27'h3, 13'h0AA}, "rotating insert replaces copy");

    // R10: illegal demap scope
    wr_cmd(2'd1, 2'd3, 1'b0, 6'd0, 51'h500, 1'b0, 13'd9, 8'd6, 27'd0, 4'b0, e);
    chk("R10", 64'(e), 64'd1, "dm_err after kind 3");
    @(negedge clk);
    chk("R10", 64'(dm_err), 64'd0, "dm_err single cycle");
    look({51'h500, 13'h0}, 13'd9, 8'd6, 1'b0);
    chk("R10", 64'(lk_hit), 64'd1, "entry kept after illegal demap");
    wr_cmd(2'd1, 2'd0, 1'b0, 6'd0, 51'h999, 1'b0, 13'd9, 8'd6, 27'd0, 4'b0, e);
    chk("R10", 64'(e), 64'd0, "no dm_err for legal demap");

    // R11: no-op leaves entries, flush empties
    wr_cmd(2'd3, 2'd0, 1'b0, 6'd0, 51'h500, 1'b0, 13'd9, 8'd6, 27'd0, 4'b0, e);
    look({51'h500, 13'h0}, 13'd9, 8'd6, 1'b0);
    chk("R11", 64'(lk_hit), 64'd1, "op 3 has no effect");
    wr_cmd(2'd2, 2'd0, 1'b0, 6'd0, 51'd0, 1'b0, 13'd0, 8'd0, 27'd0, 4'b0, e);
    look({51'h500, 13'h0}, 13'd9, 8'd6, 1'b0);
    chk("R11", 64'(lk_hit), 64'd0, "flush removes entry");
    look({51'h301, 13'h0}, 13'd1, 8'd3, 1'b0);
    chk("R11", 64'(lk_hit), 64'd0, "flush removes other partition");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule